// File: doc/BRIEF.md
# Boundary Run-Test Signature and Pattern Engine

This block is the engine behind the run-test operations of an 8-channel bidirectional boundary. Each channel has an input cell on the receiving port and an output cell on the driving port. A further output cell sits on the receiving port and is used only as the upper half of a counter. An 11-bit control register is scanned in serially and then committed with an update strobe. It holds a 3-bit operation code and one mask bit per channel. While the test controller rests in its idle state with the run-test instruction active (`run_en` high), the engine advances the cell contents once per rising clock edge. The cells are then copied into their pin-facing latches on the following falling edge.

The engine offers five operations. Toggle samples the input pins and inverts the output cells. The 16-bit pattern generator and the 16-bit signature compressor each chain the input and output cells into a single shift register. The split mode runs an 8-bit signature in the input cells and an 8-bit pattern in the output cells. The count mode runs an 8-bit signature alongside a 16-bit up-counter. The flow direction selects the receiving pins: A when only the B side drives, B when only the A side drives. With both sides driving, or neither, nothing runs. A seed-load strobe preloads the cells before a run.

Top module: `brt_engine`

## Requirements
- R1: The control register is 11 bits wide. It resets to 0x002. During `ctl_shift` a bit enters at bit 10 and bit 0 appears on `ctl_tdo`. The decoded copy changes only on `ctl_update`. Bits 2:0 are the opcode, and bit 3+k is the mask of channel k.
- R2: When opcode[1:0]=00 (toggle), a step loads the input cells from the selected pins and inverts the output cells.
- R3: When opcode[1:0]=01, a step treats v={cell_out,cell_in} as one 16-bit register: v'={v[14:0], ^(v & 0x8805)}.
- R4: When opcode[1:0]=10, a step computes v'={v[14:0], ^(v & 0x8805)} XOR {8'h00,d}, where d is the masked pin data. The output latch is not updated by such a step.
- R5: Opcode 011 runs two independent 8-bit registers. The input cells become {in[6:0], ^(in & 0x8E)} XOR d. The output cells become {out[6:0], ^(out & 0x8E)}.
- R6: Opcode 111 updates the input cells as in R5. {cell_opp,cell_out} increments by one modulo 2^16.
- R7: d[k] is pin[k] AND NOT mask[k]. The pins are pin_a when drive_b=1 and drive_a=0, and pin_b when drive_a=1 and drive_b=0.
- R8: No step happens, and all cells hold, when run_en=0 or drive_a equals drive_b.
- R9: On the falling edge after a step, latch_in copies cell_in. latch_out copies cell_out except in opcode x10. latch_opp copies cell_opp only in opcode 111.
- R10: Reset clears all cells and latches. seed_load loads the cells and takes priority over a step.
- R11: An all-zero 16-bit register stays all-zero under opcode x01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock; steps on rising edge, latches on falling edge |
| rst | input | 1 | Synchronous active-high reset (test-logic reset) |
| drive_a | input | 1 | A-side outputs enabled (B-to-A flow) |
| drive_b | input | 1 | B-side outputs enabled (A-to-B flow) |
| pin_a | input | 8 | Levels on the A pins |
| pin_b | input | 8 | Levels on the B pins |
| run_en | input | 1 | Idle state with run-test instruction active |
| ctl_shift | input | 1 | Shift the control register one place |
| ctl_update | input | 1 | Commit the shifted control value |
| ctl_tdi | input | 1 | Serial input of the control register |
| ctl_tdo | output | 1 | Serial output of the control register |
| seed_load | input | 1 | Preload the cells |
| seed_in | input | 8 | Seed for the input cells |
| seed_out | input | 8 | Seed for the output cells |
| seed_opp | input | 8 | Seed for the opposite-port output cells |
| cell_in | output | 8 | Input-cell shift contents |
| cell_out | output | 8 | Output-cell shift contents |
| cell_opp | output | 8 | Opposite-port output-cell shift contents |
| latch_in | output | 8 | Input-cell latches |
| latch_out | output | 8 | Output-cell latches toward the driven pins |
| latch_opp | output | 8 | Opposite-port output-cell latches |

## Verification
The sweep covers all eight opcodes, each under both flow directions and the two disallowed enable pairs. It uses a zero mask and a mixed 0xA5 mask. The pin levels on A and B are distinct and change every step, so a mix-up in the direction-based pin selection or in a mask position shows up in the signature. The count mode is seeded close to 0xFF so that a carry into the upper byte occurs. A zero seed under the 16-bit pattern mode checks the lock-up state. A seed load issued together with a run step checks that the load wins.

// File: rtl/brt_pkg.sv
package brt_pkg;
  typedef enum logic [2:0] {
    M_TOGGLE   = 3'd0,
    M_PRPG16   = 3'd1,
    M_PSA16    = 3'd2,
    M_PSA_PRPG = 3'd3,
    M_PSA_CNT  = 3'd4
  } brt_mode_e;

  function automatic brt_mode_e brt_decode(input logic [2:0] op);
    brt_mode_e m;
    if (op[1:0] == 2'b00)      m = M_TOGGLE;
    else if (op[1:0] == 2'b01) m = M_PRPG16;
    else if (op[1:0] == 2'b10) m = M_PSA16;
    else if (op[2] == 1'b0)    m = M_PSA_PRPG;
    else                       m = M_PSA_CNT;
    return m;
  endfunction
endpackage

// File: rtl/brt_ctl_reg.sv
module brt_ctl_reg
  import brt_pkg::*;
#(
  parameter int CH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          shift_en,
  input  logic          update_en,
  input  logic          tdi,
  output logic          tdo,
  output brt_mode_e     mode,
  output logic [CH-1:0] mask
);
  localparam int W = CH + 3;
  localparam logic [W-1:0] RST_VAL = W'(2);

  logic [W-1:0] sr_q;
  logic [W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= RST_VAL;
      sh_q <= RST_VAL;
    end else begin
      if (shift_en)  sr_q <= {tdi, sr_q[W-1:1]};
      if (update_en) sh_q <= sr_q;
    end
  end

  assign tdo  = sr_q[0];
  assign mode = brt_decode(sh_q[2:0]);
  assign mask = sh_q[W-1:3];

  // R1: reset value selects unmasked 16-bit signature
  p_ctl_reset_r1: assert property (@(posedge clk) rst |=> (mode == M_PSA16 && mask == '0));
  // R1: decoded control only moves on update
  p_ctl_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !update_en |=> ($stable(mode) && $stable(mask)));
endmodule

// File: rtl/brt_next.sv
module brt_next
  import brt_pkg::*;
#(
  parameter int CH = 8,
  parameter logic [2*CH-1:0] TAP_WIDE = 16'h8805,
  parameter logic [CH-1:0]   TAP_NARROW = 8'h8E
) (
  input  brt_mode_e     mode,
  input  logic [CH-1:0] mask,
  input  logic [CH-1:0] pins,
  input  logic [CH-1:0] in_q,
  input  logic [CH-1:0] out_q,
  input  logic [CH-1:0] opp_q,
  output logic [CH-1:0] in_n,
  output logic [CH-1:0] out_n,
  output logic [CH-1:0] opp_n
);
  localparam int WW = 2 * CH;

  logic [CH-1:0] dat;
  genvar k;
  generate
    for (k = 0; k < CH; k++) begin : g_mask
      assign dat[k] = pins[k] & ~mask[k];
    end
  endgenerate

  logic [WW-1:0] wide_q, wide_sh, cnt_n;
  logic [CH-1:0] in_sh, out_sh;

  always_comb begin
    wide_q  = {out_q, in_q};
    wide_sh = {wide_q[WW-2:0], ^(wide_q & TAP_WIDE)};
    in_sh   = {in_q[CH-2:0], ^(in_q & TAP_NARROW)} ^ dat;
    out_sh  = {out_q[CH-2:0], ^(out_q & TAP_NARROW)};
    cnt_n   = {opp_q, out_q} + WW'(1);
    in_n    = in_q;
    out_n   = out_q;
    opp_n   = opp_q;
    case (mode)
      M_TOGGLE: begin
        in_n  = pins;
        out_n = ~out_q;
      end
      M_PRPG16: begin
        {out_n, in_n} = wide_sh;
      end
      M_PSA16: begin
        {out_n, in_n} = wide_sh ^ {{CH{1'b0}}, dat};
      end
      M_PSA_PRPG: begin
        in_n  = in_sh;
        out_n = out_sh;
      end
      M_PSA_CNT: begin
        in_n           = in_sh;
        {opp_n, out_n} = cnt_n;
      end
      default: begin
        in_n = in_q;
      end
    endcase
  end
endmodule

// File: rtl/brt_cells.sv
module brt_cells #(
  parameter int CH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          step,
  input  logic          upd_out_en,
  input  logic          upd_opp_en,
  input  logic [CH-1:0] seed_in,
  input  logic [CH-1:0] seed_out,
  input  logic [CH-1:0] seed_opp,
  input  logic [CH-1:0] in_n,
  input  logic [CH-1:0] out_n,
  input  logic [CH-1:0] opp_n,
  output logic [CH-1:0] cell_in,
  output logic [CH-1:0] cell_out,
  output logic [CH-1:0] cell_opp,
  output logic [CH-1:0] latch_in,
  output logic [CH-1:0] latch_out,
  output logic [CH-1:0] latch_opp
);
  logic fl_in, fl_out, fl_opp;

  always_ff @(posedge clk) begin
    if (rst) begin
      cell_in  <= '0;
      cell_out <= '0;
      cell_opp <= '0;
      fl_in    <= 1'b0;
      fl_out   <= 1'b0;
      fl_opp   <= 1'b0;
    end else if (load) begin
      cell_in  <= seed_in;
      cell_out <= seed_out;
      cell_opp <= seed_opp;
      fl_in    <= 1'b0;
      fl_out   <= 1'b0;
      fl_opp   <= 1'b0;
    end else begin
      if (step) begin
        cell_in  <= in_n;
        cell_out <= out_n;
        cell_opp <= opp_n;
      end
      fl_in  <= step;
      fl_out <= step & upd_out_en;
      fl_opp <= step & upd_opp_en;
    end
  end

  always_ff @(negedge clk) begin
    if (rst) begin
      latch_in  <= '0;
      latch_out <= '0;
      latch_opp <= '0;
    end else begin
      if (fl_in)  latch_in  <= cell_in;
      if (fl_out) latch_out <= cell_out;
      if (fl_opp) latch_opp <= cell_opp;
    end
  end

  // R9: after a step's falling edge the input latch mirrors the input cells
  p_latch_in_r9: assert property (@(posedge clk) disable iff (rst)
    fl_in |-> (latch_in == cell_in));
endmodule

// File: rtl/brt_engine.sv
module brt_engine
  import brt_pkg::*;
#(
  parameter int CH = 8,
  parameter logic [2*CH-1:0] TAP_WIDE = 16'h8805,
  parameter logic [CH-1:0]   TAP_NARROW = 8'h8E
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          drive_a,
  input  logic          drive_b,
  input  logic [CH-1:0] pin_a,
  input  logic [CH-1:0] pin_b,
  input  logic          run_en,
  input  logic          ctl_shift,
  input  logic          ctl_update,
  input  logic          ctl_tdi,
  output logic          ctl_tdo,
  input  logic          seed_load,
  input  logic [CH-1:0] seed_in,
  input  logic [CH-1:0] seed_out,
  input  logic [CH-1:0] seed_opp,
  output logic [CH-1:0] cell_in,
  output logic [CH-1:0] cell_out,
  output logic [CH-1:0] cell_opp,
  output logic [CH-1:0] latch_in,
  output logic [CH-1:0] latch_out,
  output logic [CH-1:0] latch_opp
);
  brt_mode_e     mode;
  logic [CH-1:0] mask;
  logic [CH-1:0] pins;
  logic [CH-1:0] in_n, out_n, opp_n;
  logic          step;

  brt_ctl_reg #(.CH(CH)) u_ctl (
    .clk(clk), .rst(rst), .shift_en(ctl_shift), .update_en(ctl_update),
    .tdi(ctl_tdi), .tdo(ctl_tdo), .mode(mode), .mask(mask)
  );

  assign step = run_en & (drive_a ^ drive_b);
  assign pins = drive_b ? pin_a : pin_b;

  brt_next #(.CH(CH), .TAP_WIDE(TAP_WIDE), .TAP_NARROW(TAP_NARROW)) u_next (
    .mode(mode), .mask(mask), .pins(pins),
    .in_q(cell_in), .out_q(cell_out), .opp_q(cell_opp),
    .in_n(in_n), .out_n(out_n), .opp_n(opp_n)
  );

  brt_cells #(.CH(CH)) u_cells (
    .clk(clk), .rst(rst), .load(seed_load), .step(step),
    .upd_out_en(mode != M_PSA16), .upd_opp_en(mode == M_PSA_CNT),
    .seed_in(seed_in), .seed_out(seed_out), .seed_opp(seed_opp),
    .in_n(in_n), .out_n(out_n), .opp_n(opp_n),
    .cell_in(cell_in), .cell_out(cell_out), .cell_opp(cell_opp),
    .latch_in(latch_in), .latch_out(latch_out), .latch_opp(latch_opp)
  );

  // R8: no valid step and no load means every cell holds
  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!seed_load && !(run_en && (drive_a != drive_b)))
      |=> ($stable(cell_in) && $stable(cell_out) && $stable(cell_opp)));
  // R2: toggle inverts output cells
  p_toggle_r2: assert property (@(posedge clk) disable iff (rst)
    (step && !seed_load && mode == M_TOGGLE) |=> (cell_out == ~$past(cell_out)));
  // R6: count mode increments the 16-bit output pair
  p_count_r6: assert property (@(posedge clk) disable iff (rst)
    (step && !seed_load && mode == M_PSA_CNT)
      |=> ({cell_opp, cell_out} == $past({cell_opp, cell_out}) + 16'd1));
  // R4: signature mode leaves the output latch alone
  p_psa_latch_r4: assert property (@(posedge clk) disable iff (rst)
    (step && !seed_load && mode == M_PSA16) |=> $stable(latch_out));
  // R11: zero state locks under the wide pattern generator
  p_zero_lock_r11: assert property (@(posedge clk) disable iff (rst)
    (step && !seed_load && mode == M_PRPG16 && cell_in == '0 && cell_out == '0)
      |=> (cell_in == '0 && cell_out == '0));
endmodule

// File: tb/brt_engine_test.sv
module brt_engine_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic drive_a = 1'b0, drive_b = 1'b0;
  logic [7:0] pin_a = '0, pin_b = '0;
  logic run_en = 1'b0;
  logic ctl_shift = 1'b0, ctl_update = 1'b0, ctl_tdi = 1'b0;
  logic ctl_tdo;
  logic seed_load = 1'b0;
  logic [7:0] seed_in = '0, seed_out = '0, seed_opp = '0;
  logic [7:0] cell_in, cell_out, cell_opp, latch_in, latch_out, latch_opp;

  always #4 clk = ~clk;

  brt_engine uut (
    .clk(clk), .rst(rst), .drive_a(drive_a), .drive_b(drive_b),
    .pin_a(pin_a), .pin_b(pin_b), .run_en(run_en),
    .ctl_shift(ctl_shift), .ctl_update(ctl_update), .ctl_tdi(ctl_tdi), .ctl_tdo(ctl_tdo),
    .seed_load(seed_load), .seed_in(seed_in), .seed_out(seed_out), .seed_opp(seed_opp),
    .cell_in(cell_in), .cell_out(cell_out), .cell_opp(cell_opp),
    .latch_in(latch_in), .latch_out(latch_out), .latch_opp(latch_opp)
  );

  int nvec = 0;
  int nerr = 0;
  logic [10:0] m_sr, m_ctl;
  logic [7:0] m_in, m_out, m_opp, l_in, l_out, l_opp;
  logic f_in, f_out, f_opp;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string op_tag(input logic [2:0] op, input logic [7:0] mask);
    if (op[1:0] == 2'b00) return "R2";
    if (op[1:0] == 2'b01) return "R3";
    if (mask != 8'h00)    return "R7";
    if (op[1:0] == 2'b10) return "R4";
    if (op[2] == 1'b0)    return "R5";
    return "R6";
  endfunction

  // expected next cells from the requirement formulas
  task automatic model_pre();
    logic [2:0] op;
    logic [7:0] mask, pins, d;
    logic [15:0] v, vn;
    op = m_ctl[2:0];
    mask = m_ctl[10:3];
    pins = drive_b ? pin_a : pin_b;
    d = pins & ~mask;
    v = {m_out, m_in};
    f_in = 1'b0; f_out = 1'b0; f_opp = 1'b0;
    if (seed_load) begin
      m_in = seed_in; m_out = seed_out; m_opp = seed_opp;
    end else if (run_en && (drive_a != drive_b)) begin
      f_in = 1'b1;
      f_out = (op[1:0] != 2'b10);
      f_opp = (op == 3'b111);
      if (op[1:0] == 2'b00) begin
        m_in = pins; m_out = ~m_out;
      end else if (op[1:0] == 2'b01) begin
        vn = {v[14:0], ^(v & 16'h8805)};
        {m_out, m_in} = vn;
      end else if (op[1:0] == 2'b10) begin
        vn = {v[14:0], ^(v & 16'h8805)} ^ {8'h00, d};
        {m_out, m_in} = vn;
      end else begin
        m_in = {m_in[6:0], ^(m_in & 8'h8E)} ^ d;
        if (op[2] == 1'b0) m_out = {m_out[6:0], ^(m_out & 8'h8E)};
        else {m_opp, m_out} = {m_opp, m_out} + 16'd1;
      end
    end
  endtask

  task automatic cycle(input string tag);
    model_pre();
    @(posedge clk); #2;
    chk(tag, {8'h00, cell_in}, {8'h00, m_in});
    chk(tag, {8'h00, cell_out}, {8'h00, m_out});
    chk(tag, {8'h00, cell_opp}, {8'h00, m_opp});
    @(negedge clk); #1;
    if (f_in) l_in = m_in;
    if (f_out) l_out = m_out;
    if (f_opp) l_opp = m_opp;
    chk("R9", {8'h00, latch_in}, {8'h00, l_in});
    chk("R9", {8'h00, latch_out}, {8'h00, l_out});
    chk("R9", {8'h00, latch_opp}, {8'h00, l_opp});
  endtask

  task automatic scan_ctl(input logic [10:0] v);
    run_en = 1'b0;
    for (int i = 0; i < 11; i++) begin
      ctl_shift = 1'b1;
      ctl_tdi = v[i];
      chk("R1", {15'h0, ctl_tdo}, {15'h0, m_sr[0]});
      @(posedge clk); #1;
      m_sr = {v[i], m_sr[10:1]};
      @(negedge clk); #1;
    end
    ctl_shift = 1'b0;
    ctl_update = 1'b1;
    @(posedge clk); #1;
    m_ctl = m_sr;
    @(negedge clk); #1;
    ctl_update = 1'b0;
  endtask

  task automatic do_seed(input logic [7:0] si, input logic [7:0] so, input logic [7:0] sp);
    seed_load = 1'b1; seed_in = si; seed_out = so; seed_opp = sp;
    cycle("R10");
    seed_load = 1'b0;
  endtask

  initial begin
    #1200000;
    nerr++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end

  initial begin
    m_sr = 11'h002; m_ctl = 11'h002;
    m_in = '0; m_out = '0; m_opp = '0; l_in = '0; l_out = '0; l_opp = '0;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    // R10: reset state
    chk("R10", {cell_in, cell_out}, 16'h0000);
    chk("R10", {cell_opp, latch_in}, 16'h0000);
    chk("R10", {latch_out, latch_opp}, 16'h0000);

    for (int op = 0; op < 8; op++) begin
      for (int mk = 0; mk < 2; mk++) begin
        logic [7:0] mask;
        mask = (mk == 0) ? 8'h00 : 8'hA5;
        // R1: scanned-out bits reveal the previous contents (reset 0x002 first)
        scan_ctl({mask, op[2:0]});
        for (int ds = 0; ds < 4; ds++) begin
          drive_a = (ds == 1) || (ds == 3);
          drive_b = (ds == 0) || (ds == 3);
          run_en = 1'b0;
          do_seed(8'h3C ^ 8'(op * 17) ^ 8'(ds),
                  (op == 7) ? 8'hFA : 8'h81 + 8'(op * 3), 8'hFE);
          run_en = 1'b1;
          for (int s = 0; s < 10; s++) begin
            pin_a = 8'(s * 37) + 8'(op * 5) + 8'h1B;
            pin_b = (8'(s * 91) ^ 8'hC4) + 8'(ds);
            cycle((ds >= 2) ? "R8" : op_tag(op[2:0], mask));
          end
          run_en = 1'b0;
        end
      end
    end

    // R8: run_en low with a valid direction
    drive_a = 1'b0; drive_b = 1'b1;
    scan_ctl(11'h001);
    do_seed(8'h12, 8'h34, 8'h56);
    run_en = 1'b0;
    for (int s = 0; s < 3; s++) begin
      pin_a = 8'(s * 13 + 5);
      cycle("R8");
    end

    // R10: seed load wins over a concurrent step
    run_en = 1'b1;
    do_seed(8'h9C, 8'h47, 8'h21);

    // R11: zero seed stays zero in the wide pattern mode
    run_en = 1'b0;
    do_seed(8'h00, 8'h00, 8'h00);
    run_en = 1'b1;
    for (int s = 0; s < 4; s++) begin
      pin_a = 8'hFF;
      cycle("R11");
    end
    run_en = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule